// File: doc/BRIEF.md
# SPI Master with Phase-Pattern Sequencer

This block is a register-driven SPI master. A host reaches it through a simple single-cycle register port. Bytes written to the data register go into a transmit FIFO, and bytes read from the data register come out of a receive FIFO. A write to the command register starts one transfer. A sequencer runs that transfer as an ordered list of up to three phases. Each phase is one of: write, read, simultaneous write/read, or dummy. Each phase has its own frame count.

The sequencer drives one active-low chip select, a serial clock and a serial output, and it samples the serial input. Clock mode 0 is used: the clock idles low, data is sampled on the rising edge and shifted on the falling edge. Frames go out most significant bit first. A divider sets the serial clock rate. Three self-clearing reset bits flush the FIFOs or abort the whole engine. A status word reports the FIFO fill levels and a busy flag.

Register offsets:

| Register | Offset |
|---|---|
| format | 0x10 |
| command | 0x20 |
| data | 0x2C |
| control | 0x30 |
| status | 0x34 |
| timing | 0x40 |

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the block is idle. Chip select is high and the serial clock is low. Status (0x34) reads exactly 0x0040_0000: only the TX-empty bit 22 is set. Format (0x10) reads 0x0000_0700, meaning 8-bit frames. Timing (0x40) reads 0 and control (0x30) reads 0.
- R2: Command code 1 (command bits 27:24) shifts out frame-count-plus-one frames, where the write count is in command bits 20:12. Each frame is popped from the TX FIFO and sent MSB first. MOSI changes only while the clock is low. Nothing enters the RX FIFO.
- R3: Command code 2 clocks in read-count-plus-one frames, where the read count is in command bits 8:0. MOSI is held low. Each received frame is pushed into the RX FIFO, and reads of the data register (0x2C) return the frames in arrival order.
- R4: Command code 0 runs write-count-plus-one frames. Each frame both transmits a TX FIFO byte and stores the received frame.
- R5: Code 3 runs the write frames and then the read frames. Code 4 runs the read frames and then the write frames. Both happen under one chip-select assertion.
- R6: A dummy phase is exactly one 8-bit frame with MOSI low, and its received data is discarded. The dummy codes are: 5 (write, dummy, read), 6 (read, dummy, write), 8 (dummy, write) and 9 (dummy, read).
- R7: Code 7 and the unassigned codes 10 to 15 produce no serial clock edge, and busy returns to 0. The serial clock is never high while chip select is high.
- R8: Each serial clock half-period lasts div+1 system clocks, where div is timing bits 7:0. The value 0xFF selects a one-cycle half-period.
- R9: Format bits 10:8 hold the frame width minus one. A width below 8 sends the low bits of the TX byte MSB first, and received frames are right-aligned.
- R10: When the RX FIFO is full, the next read frame does not start and the serial clock stops. The transfer resumes once an entry is popped, and no data is lost.
- R11: The control register reset bits are: bit 0 empties the TX FIFO, bit 1 empties the RX FIFO, and bit 2 aborts the transfer and empties both FIFOs. Each bit clears itself within two cycles.
- R12: Status bit 0 (busy) is set from the command write until chip select returns high. Status bits 20:16 report the TX FIFO fill level and bits 12:8 report the RX FIFO fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX FIFO at data offset) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong phase index or frame counter shows up on the wire as a frame that is missing, extra or misplaced. A serial-side model catches this when the command ends, by comparing every captured frame and the RX FIFO contents with an order computed from the command code. A wrong timer or stall decision changes the measured spacing between rising clock edges within a single bit period, or lets the rising-edge count move while the RX FIFO is full. A bad reset path shows up in the status fill levels two cycles after the control write.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Register offsets
    localparam logic [7:0] A_FMT  = 8'h10;
    localparam logic [7:0] A_CMD  = 8'h20;
    localparam logic [7:0] A_DATA = 8'h2C;
    localparam logic [7:0] A_CTRL = 8'h30;
    localparam logic [7:0] A_STAT = 8'h34;
    localparam logic [7:0] A_TIM  = 8'h40;

    typedef enum logic [2:0] {
        PK_NONE, PK_WR, PK_RD, PK_WRRD, PK_DUMMY
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LEAD, S_PHASE, S_FRAME, S_LO, S_HI, S_TRAIL
    } seq_st_e;

    // Phase kind at position idx of the pattern selected by code
    function automatic phase_e phase_at(input logic [3:0] code, input logic [1:0] idx);
        phase_e p0, p1, p2;
        p0 = PK_NONE; p1 = PK_NONE; p2 = PK_NONE;
        case (code)
            4'd0: p0 = PK_WRRD;
            4'd1: p0 = PK_WR;
            4'd2: p0 = PK_RD;
            4'd3: begin p0 = PK_WR; p1 = PK_RD; end
            4'd4: begin p0 = PK_RD; p1 = PK_WR; end
            4'd5: begin p0 = PK_WR; p1 = PK_DUMMY; p2 = PK_RD; end
            4'd6: begin p0 = PK_RD; p1 = PK_DUMMY; p2 = PK_WR; end
            4'd8: begin p0 = PK_DUMMY; p1 = PK_WR; end
            4'd9: begin p0 = PK_DUMMY; p1 = PK_RD; end
            default: ;
        endcase
        case (idx)
            2'd0:    return p0;
            2'd1:    return p1;
            2'd2:    return p2;
            default: return PK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rp];
    assign count   = q.cnt;

    always_comb begin
        d = q;
        if (do_push) d.wp = q.wp + 1'b1;
        if (do_pop)  d.rp = q.rp + 1'b1;
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end
endmodule

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 9,
    parameter int DIV_W = 8,
    localparam int BW   = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [3:0]       code,
    input  logic [CNT_W-1:0] wcnt,
    input  logic [CNT_W-1:0] rcnt,
    input  logic [BW-1:0]    flen,
    input  logic [DIV_W-1:0] div,
    input  logic [DW-1:0]    tx_data,
    input  logic             tx_empty,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [DW-1:0]    rx_data,
    output logic             busy,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    typedef struct packed {
        seq_st_e          st;
        logic [3:0]       code;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rcnt;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       ph;
        logic [DIV_W:0]   tmr;
        logic [BW-1:0]    bitc;
        logic [DW-1:0]    sho;
        logic [DW-1:0]    shi;
        logic             sclk;
        logic             cs_n;
    } seq_t;

    seq_t q, d;
    phase_e kind;
    logic [DIV_W:0] hp_m1;
    logic tdone, wr_k, rd_k, in_dummy;

    assign hp_m1    = (div == '1) ? '0 : {1'b0, div};
    assign tdone    = (q.tmr == hp_m1);
    assign kind     = phase_at(q.code, q.ph);
    assign wr_k     = (kind == PK_WR) || (kind == PK_WRRD);
    assign rd_k     = (kind == PK_RD) || (kind == PK_WRRD);
    assign in_dummy = (kind == PK_DUMMY) && ((q.st == S_LO) || (q.st == S_HI));

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        case (q.st)
            S_IDLE: begin
                d.sclk = 1'b0;
                d.cs_n = 1'b1;
                if (start) begin
                    d.code = code;
                    d.wcnt = wcnt;
                    d.rcnt = rcnt;
                    d.ph   = '0;
                    d.tmr  = '0;
                    d.sho  = '0;
                    d.cs_n = 1'b0;
                    d.st   = S_LEAD;
                end
            end
            S_LEAD, S_TRAIL: begin
                if (tdone) begin
                    d.tmr = '0;
                    if (q.st == S_LEAD) d.st = S_PHASE;
                    else begin d.cs_n = 1'b1; d.st = S_IDLE; end
                end else d.tmr = q.tmr + 1'b1;
            end
            S_PHASE: begin
                if (kind == PK_NONE) begin
                    d.tmr = '0;
                    d.st  = S_TRAIL;
                end else begin
                    d.cnt = (kind == PK_RD) ? q.rcnt : (kind == PK_DUMMY) ? '0 : q.wcnt;
                    d.st  = S_FRAME;
                end
            end
            S_FRAME: begin
                if (!((wr_k && tx_empty) || (rd_k && rx_full))) begin
                    tx_pop = wr_k;
                    d.sho  = wr_k ? (tx_data << (BW'(DW - 1) - flen)) : '0;
                    d.shi  = '0;
                    d.bitc = (kind == PK_DUMMY) ? BW'(DW - 1) : flen;
                    d.tmr  = '0;
                    d.st   = S_LO;
                end
            end
            S_LO: begin
                if (tdone) begin
                    d.sclk = 1'b1;
                    d.shi  = {q.shi[DW-2:0], miso};
                    d.tmr  = '0;
                    d.st   = S_HI;
                end else d.tmr = q.tmr + 1'b1;
            end
            S_HI: begin
                if (tdone) begin
                    d.sclk = 1'b0;
                    d.tmr  = '0;
                    if (q.bitc == '0) begin
                        rx_push = rd_k;
                        if (q.cnt == '0) begin
                            d.ph = q.ph + 1'b1;
                            d.st = S_PHASE;
                        end else begin
                            d.cnt = q.cnt - 1'b1;
                            d.st  = S_FRAME;
                        end
                    end else begin
                        d.bitc = q.bitc - 1'b1;
                        d.sho  = q.sho << 1;
                        d.st   = S_LO;
                    end
                end else d.tmr = q.tmr + 1'b1;
            end
            default: d.st = S_IDLE;
        endcase
        if (abort) begin
            d      = '0;
            d.cs_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data = q.shi;
    assign busy    = (q.st != S_IDLE);
    assign sclk    = q.sclk;
    assign cs_n    = q.cs_n;
    assign mosi    = q.sho[DW-1];
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FRAME_W    = 8,
    parameter int CNT_W      = 9,
    parameter int DIV_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int BW = $clog2(FRAME_W);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [BW-1:0]    flen;
        logic [DIV_W-1:0] div;
        logic [3:0]       code;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rcnt;
        logic [2:0]       rstp;
    } regs_t;

    regs_t q, d;
    logic busy, start, tx_wr, rx_rd;
    logic tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
    logic [FRAME_W-1:0] tx_head, rx_head, rx_in;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign start = bus_wr && (bus_addr == A_CMD) && !busy && !q.rstp[2];
    assign tx_wr = bus_wr && (bus_addr == A_DATA);
    assign rx_rd = bus_rd && (bus_addr == A_DATA);

    always_comb begin
        d      = q;
        d.rstp = '0;
        if (bus_wr) begin
            case (bus_addr)
                A_FMT:  d.flen = bus_wdata[8 +: BW];
                A_TIM:  d.div  = bus_wdata[DIV_W-1:0];
                A_CTRL: d.rstp = bus_wdata[2:0];
                A_CMD: if (start) begin
                    d.code = bus_wdata[27:24];
                    d.wcnt = bus_wdata[12 +: CNT_W];
                    d.rcnt = bus_wdata[0 +: CNT_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.flen <= BW'(FRAME_W - 1);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_FMT:  bus_rdata[8 +: BW] = q.flen;
            A_TIM:  bus_rdata[DIV_W-1:0] = q.div;
            A_CTRL: bus_rdata[2:0] = q.rstp;
            A_CMD: begin
                bus_rdata[27:24]        = q.code;
                bus_rdata[12 +: CNT_W]  = q.wcnt;
                bus_rdata[0 +: CNT_W]   = q.rcnt;
            end
            A_DATA: if (!rx_empty) bus_rdata[FRAME_W-1:0] = rx_head;
            A_STAT: begin
                bus_rdata[0]       = busy;
                bus_rdata[22]      = tx_empty;
                bus_rdata[16 +: CW] = tx_cnt;
                bus_rdata[8 +: CW]  = rx_cnt;
            end
            default: ;
        endcase
    end

    spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(q.rstp[0] | q.rstp[2]),
        .push(tx_wr), .wdata(bus_wdata[FRAME_W-1:0]), .pop(tx_pop),
        .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(q.rstp[1] | q.rstp[2]),
        .push(rx_push), .wdata(rx_in), .pop(rx_rd),
        .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_seq #(.DW(FRAME_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .abort(q.rstp[2]), .start(start),
        .code(bus_wdata[27:24]), .wcnt(bus_wdata[12 +: CNT_W]),
        .rcnt(bus_wdata[0 +: CNT_W]), .flen(q.flen), .div(q.div),
        .tx_data(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_in),
        .busy(busy), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .miso(spi_miso)
    );

    logic unused_txfull;
    assign unused_txfull = tx_full;
endmodule

// File: rtl/spim_seq_chk.sv
module spim_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy,
    input logic tx_pop,
    input logic tx_empty,
    input logic rx_push,
    input logic rx_full,
    input logic in_dummy
);
    a_r10_no_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    a_r2_no_tx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    a_r7_clock_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

    a_r6_dummy_low: assert property (@(posedge clk) disable iff (!rst_n)
        in_dummy |-> !mosi);

    a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

bind spim_seq spim_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .busy(busy), .tx_pop(tx_pop), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_full(rx_full), .in_dummy(in_dummy)
);

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb;
    localparam logic [7:0] FMT = 8'h10, CMD = 8'h20, DAT = 8'h2C;
    localparam logic [7:0] CTL = 8'h30, STA = 8'h34, TIM = 8'h40;

    // {code, write count, read count}
    localparam logic [21:0] VEC [11] = '{
        {4'd1, 9'd3, 9'd0}, {4'd2, 9'd0, 9'd4}, {4'd0, 9'd2, 9'd0},
        {4'd3, 9'd1, 9'd2}, {4'd4, 9'd2, 9'd1}, {4'd5, 9'd0, 9'd1},
        {4'd6, 9'd1, 9'd0}, {4'd8, 9'd2, 9'd0}, {4'd9, 9'd0, 9'd2},
        {4'd7, 9'd0, 9'd0}, {4'd12, 9'd1, 9'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0, bus_rdata;
    logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #2 clk = ~clk;

    spim_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc++;

    // Serial-side model
    int sw = 8, bcnt = 0, nfr = 0, nrise = 0, last_rise = 0, per_cyc = 0;
    logic [7:0] sh = 8'h0;
    logic [7:0] wire_q [64];
    logic [7:0] cur_s;

    function automatic logic [7:0] sval(input int i);
        return 8'(8'hC1 + i * 19);
    endfunction

    assign cur_s    = sval(nfr);
    assign spi_miso = (bcnt < sw) ? cur_s[sw - 1 - bcnt] : 1'b0;

    always @(negedge spi_cs_n) begin
        bcnt = 0; nfr = 0; sh = 8'h0;
    end

    always @(posedge spi_sclk) begin
        sh = {sh[6:0], spi_mosi};
        bcnt++; nrise++;
        per_cyc = cyc - last_rise;
        last_rise = cyc;
        if (bcnt == sw) begin
            if (nfr < 64) wire_q[nfr] = sh;
            nfr++; bcnt = 0; sh = 8'h0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dv);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = dv;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] dv);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 dv = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(STA, s);
            if (!s[0]) break;
        end
    endtask

    // 0 none, 1 write, 2 read, 3 write+read, 4 dummy
    function automatic int kind(input int code, input int idx);
        int p [3];
        p = '{0, 0, 0};
        case (code)
            0: p[0] = 3;
            1: p[0] = 1;
            2: p[0] = 2;
            3: p = '{1, 2, 0};
            4: p = '{2, 1, 0};
            5: p = '{1, 4, 2};
            6: p = '{2, 4, 1};
            8: p = '{4, 1, 0};
            9: p = '{4, 2, 0};
            default: ;
        endcase
        return p[idx];
    endfunction

    function automatic string tagof(input int code);
        case (code)
            0: return "R4";
            1: return "R2";
            2: return "R3";
            3, 4: return "R5";
            5, 6, 8, 9: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_cmd(input int code, input int wc, input int rc, input string tag);
        logic [7:0] txb [64];
        logic [7:0] ew [64];
        logic [7:0] er [64];
        logic [31:0] s;
        logic [7:0] mask;
        int nw, f, nr, ti, r0;
        nw = 0; f = 0; nr = 0; ti = 0;
        mask = 8'((1 << sw) - 1);
        for (int i = 0; i < 3; i++) if (kind(code, i) == 1 || kind(code, i) == 3) nw = wc + 1;
        for (int k = 0; k < nw; k++) begin
            txb[k] = 8'(code * 37 + k * 11 + 5);
            wr(DAT, {24'h0, txb[k]});
        end
        for (int i = 0; i < 3; i++) begin
            int k, n;
            k = kind(code, i);
            n = (k == 0) ? 0 : (k == 4) ? 1 : (k == 2) ? rc + 1 : wc + 1;
            for (int j = 0; j < n; j++) begin
                ew[f] = (k == 1 || k == 3) ? (txb[ti] & mask) : 8'h0;
                if (k == 1 || k == 3) ti++;
                if (k == 2 || k == 3) begin er[nr] = sval(f) & mask; nr++; end
                f++;
            end
        end
        r0 = nrise;
        wr(CMD, (32'(code) << 24) | (32'(wc) << 12) | 32'(rc));
        wait_idle();
        check({tag, " frame count"}, 32'(nfr), 32'(f));
        check({tag, " clock edges"}, 32'(nrise - r0), 32'(f * sw));
        for (int i = 0; i < f; i++) check({tag, " mosi frame"}, {24'h0, wire_q[i]}, {24'h0, ew[i]});
        rd(STA, s);
        check({tag, " R12 rx level"}, {27'h0, s[12:8]}, 32'(nr));
        check({tag, " R12 tx level"}, {27'h0, s[20:16]}, 32'h0);
        for (int i = 0; i < nr; i++) begin
            rd(DAT, s);
            check({tag, " rx data"}, s, {24'h0, er[i]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish act=running exp=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] s;
        int r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 cs_n", {31'h0, spi_cs_n}, 32'h1);
        check("R1 sclk", {31'h0, spi_sclk}, 32'h0);
        rd(STA, s); check("R1 status", s, 32'h0040_0000);
        rd(FMT, s); check("R1 format", s, 32'h0000_0700);
        rd(TIM, s); check("R1 timing", s, 32'h0);
        rd(CTL, s); check("R1 control", s, 32'h0);

        // Table of commands
        for (int v = 0; v < 11; v++)
            run_cmd(int'(VEC[v][21:18]), int'(VEC[v][17:9]), int'(VEC[v][8:0]),
                    tagof(int'(VEC[v][21:18])));

        // R9 narrow frames
        wr(FMT, 32'h0000_0300); sw = 4;
        run_cmd(0, 1, 0, "R9");
        wr(FMT, 32'h0000_0700); sw = 8;

        // R8 divider
        wr(TIM, 32'h3);
        run_cmd(1, 0, 0, "R8");
        check("R8 period div3", 32'(per_cyc), 32'd8);
        wr(TIM, 32'hFF);
        run_cmd(1, 0, 0, "R8");
        check("R8 period divFF", 32'(per_cyc), 32'd2);
        wr(TIM, 32'h0);
        run_cmd(1, 0, 0, "R8");
        check("R8 period div0", 32'(per_cyc), 32'd2);

        // R10 stall on full RX FIFO
        wr(CMD, (32'd2 << 24) | 32'd19);
        repeat (400) @(negedge clk);
        rd(STA, s);
        check("R10 rx level at stall", {27'h0, s[12:8]}, 32'd16);
        check("R10 busy during stall", {31'h0, s[0]}, 32'h1);
        r0 = nrise;
        repeat (60) @(negedge clk);
        check("R10 clock stopped", 32'(nrise - r0), 32'd0);
        for (int i = 0; i < 16; i++) begin
            rd(DAT, s);
            check("R10 rx data", s, {24'h0, sval(i)});
        end
        wait_idle();
        rd(STA, s);
        check("R10 rx level after", {27'h0, s[12:8]}, 32'd4);
        for (int i = 16; i < 20; i++) begin
            rd(DAT, s);
            check("R10 rx data tail", s, {24'h0, sval(i)});
        end

        // R11 self-clearing resets
        wr(DAT, 32'h11); wr(DAT, 32'h22); wr(DAT, 32'h33);
        rd(STA, s); check("R12 tx level", {27'h0, s[20:16]}, 32'd3);
        wr(CTL, 32'h1);
        rd(STA, s);
        check("R11 tx flushed", {27'h0, s[20:16]}, 32'd0);
        check("R11 tx empty bit", {31'h0, s[22]}, 32'h1);
        rd(CTL, s); check("R11 ctrl self-clear", s, 32'h0);
        wr(CMD, (32'd2 << 24) | 32'd2);
        wait_idle();
        rd(STA, s); check("R11 rx before flush", {27'h0, s[12:8]}, 32'd3);
        wr(CTL, 32'h2);
        rd(STA, s); check("R11 rx flushed", {27'h0, s[12:8]}, 32'd0);
        wr(TIM, 32'd20);
        wr(CMD, (32'd2 << 24) | 32'd9);
        repeat (30) @(negedge clk);
        rd(STA, s);
        check("R12 busy mid command", {31'h0, s[0]}, 32'h1);
        check("R11 cs low mid command", {31'h0, spi_cs_n}, 32'h0);
        wr(CTL, 32'h4);
        rd(STA, s);
        check("R11 abort busy", {31'h0, s[0]}, 32'h0);
        check("R11 abort cs", {31'h0, spi_cs_n}, 32'h1);
        rd(CTL, s); check("R11 ctrl clear after abort", s, 32'h0);
        wr(TIM, 32'h0);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule